// File: doc/BRIEF.md
# Dual-Source Baud Tick Generator

This block produces the single-cycle tick enable that paces a serial transmitter or receiver. Software writes one 32-bit configuration word. The word holds a 23-bit divide-minus-one value, an enable flag that makes the word take effect, a source-select flag, and a prescaler-select flag. With the crystal source chosen, the block counts crystal edges, which arrive as one-cycle strobes already in the system clock domain. The crystal is first divided by 3, or by 2 when the fast-prescaler flag is set. With the peripheral source chosen, the block counts system clock cycles, first divided by 4.

The prescaled clock then drives a 23-bit counter. That counter raises the output tick once every divisor-plus-one prescaled periods. To reach a rate B from a prescaled frequency F, software programs round(F / B) - 1. Every write reloads both counters, so the first period after a write already follows the new setting.

Top module: `baud_tick_gen`

## Requirements
- R1: A pulse on `cfg_wr` captures `cfg_wdata` at that clock edge. Bits 22:0 of the word are the divisor N, stored as the period count minus one.
- R2: While bit 23 of the captured word is 0, both counters are held at zero and `tick_o` stays low.
- R3: When bit 24 is 1, the prescaler advances only on cycles where `xtal_ce` is high. With no `xtal_ce` strobes, no tick is produced.
- R4: With bit 24 set, the prescale ratio is 3 when bit 27 is 0 and 2 when bit 27 is 1. The tick period is ratio·(N+1)·S cycles when `xtal_ce` pulses once every S cycles.
- R5: With bit 24 clear, every system clock cycle counts, the prescale ratio is 4, and bit 27 has no effect. The tick period is 4·(N+1) cycles.
- R6: `tick_o` is high for exactly one cycle per period and never on two consecutive cycles.
- R7: A write clears both counters. The tick is low in the cycle after the write edge. With the peripheral source, the first tick comes exactly 4·(N+1) cycles after the write edge, whatever count was in progress.
- R8: After reset, the captured word is zero, so the generator is disabled and `tick_o` is low.
- R9: Bits 31:28 and 26:25 of the word have no effect on the tick period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | One-cycle strobe that loads the configuration word |
| cfg_wdata | input | 32 | Configuration word (divisor, enable, source, prescaler select) |
| xtal_ce | input | 1 | One-cycle strobe per crystal clock edge, synchronous to `clk` |
| tick_o | output | 1 | One-cycle rate tick |

## Verification
The period is measured between consecutive ticks for each row of a vector table. The rows cover:
- the peripheral source at a small, a medium and a large divisor;
- both crystal prescale ratios with a strobe on every cycle, which separates ratio 2 from ratio 3;
- sparse crystal strobes, which show that the prescaler counts strobes and not cycles;
- the fast-prescaler flag set with the peripheral source, which shows the flag is ignored there;
- a word full of spare bits, which shows those bits change nothing.

Directed cases cover three more points. They measure the exact latency from a write to the first tick, both after idle and when a longer count is interrupted. They confirm silence when the enable flag is clear, and silence when the crystal source is chosen but never strobes.

// File: rtl/baudgen_pkg.sv
// Shared field layout and decoded configuration type of the baud tick generator.
// Assumes a 32-bit configuration word; bit positions are fixed by software.
package baudgen_pkg;
    localparam int DIV_W     = 23;
    localparam int EN_BIT    = 23;
    localparam int XSEL_BIT  = 24;
    localparam int XFAST_BIT = 27;

    typedef struct packed {
        logic             en;
        logic             xtal_sel;
        logic             xtal_fast;
        logic [DIV_W-1:0] div_m1;
    } bg_cfg_t;

    // Extracts the used fields from a raw configuration word.
    function automatic bg_cfg_t decode_cfg(input logic [31:0] w);
        bg_cfg_t c;
        c.en        = w[EN_BIT];
        c.xtal_sel  = w[XSEL_BIT];
        c.xtal_fast = w[XFAST_BIT];
        c.div_m1    = w[DIV_W-1:0];
        return c;
    endfunction
endpackage

// File: rtl/bg_src_prescaler.sv
// Source selection and fixed prescaler.
// Counts either every clk cycle (peripheral source) or only xtal_ce cycles
// (crystal source) and emits step_o on the last count of each prescale period.
// Assumes the ratio inputs change only together with a clear.
module bg_src_prescaler #(
    parameter int PCLK_DIV      = 4,
    parameter int XTAL_DIV_SLOW = 3,
    parameter int XTAL_DIV_FAST = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic xtal_sel,
    input  logic xtal_fast,
    input  logic xtal_ce,
    output logic step_o
);
    localparam int XMAX    = (XTAL_DIV_SLOW > XTAL_DIV_FAST) ? XTAL_DIV_SLOW : XTAL_DIV_FAST;
    localparam int MAX_DIV = (PCLK_DIV > XMAX) ? PCLK_DIV : XMAX;
    localparam int PRE_W   = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;
    localparam logic [PRE_W-1:0] PCLK_LAST = PRE_W'(PCLK_DIV - 1);
    localparam logic [PRE_W-1:0] SLOW_LAST = PRE_W'(XTAL_DIV_SLOW - 1);
    localparam logic [PRE_W-1:0] FAST_LAST = PRE_W'(XTAL_DIV_FAST - 1);

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] last;
    logic             src_ce;

    // Picks the counting strobe and the terminal count for the chosen source.
    always_comb begin
        src_ce = xtal_sel ? xtal_ce : 1'b1;
        if (!xtal_sel)      last = PCLK_LAST;
        else if (xtal_fast) last = FAST_LAST;
        else                last = SLOW_LAST;
    end

    assign step_o = src_ce && (cnt_q == last);

    // Prescale counter: wraps at the terminal count, cleared on reload or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)  cnt_q <= '0;
        else if (src_ce)      cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
    end

    // R4
    pre_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last);
    // R3
    pre_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && !clear) |=> (cnt_q == '0));
endmodule

// File: rtl/bg_tick_divider.sv
// Divide-minus-one counter: on every step it advances, and on the step where
// it equals limit it wraps and raises tick_o for one cycle.
// Assumes limit changes only together with a clear.
module bg_tick_divider #(
    parameter int DIV_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [DIV_W-1:0] limit,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;
    logic             tick_q;

    // Main counter and registered tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (step) begin
            if (cnt_q == limit) begin
                cnt_q  <= '0;
                tick_q <= 1'b1;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
                tick_q <= 1'b0;
            end
        end else begin
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q;

    // R1
    div_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);
endmodule

// File: rtl/baud_tick_gen.sv
// Top of the dual-source baud tick generator.
// Holds the configuration word, reloads both counters on each write and keeps
// them cleared while the enable flag is off. xtal_ce must already be
// synchronous to clk and at most one cycle wide per crystal edge.
module baud_tick_gen (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    input  logic        xtal_ce,
    output logic        tick_o
);
    import baudgen_pkg::*;

    bg_cfg_t cfg_q;
    logic    hold_clr;
    logic    pre_step;
    logic    cfg_unused_bits;

    assign cfg_unused_bits = ^{cfg_wdata[31:28], cfg_wdata[26:25]};

    // Configuration register, loaded by the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= decode_cfg(cfg_wdata);
    end

    assign hold_clr = cfg_wr || !cfg_q.en;

    bg_src_prescaler #(
        .PCLK_DIV      (4),
        .XTAL_DIV_SLOW (3),
        .XTAL_DIV_FAST (2)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (hold_clr),
        .xtal_sel  (cfg_q.xtal_sel),
        .xtal_fast (cfg_q.xtal_fast),
        .xtal_ce   (xtal_ce),
        .step_o    (pre_step)
    );

    bg_tick_divider #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (hold_clr),
        .step   (pre_step),
        .limit  (cfg_q.div_m1),
        .tick_o (tick_o)
    );

    // R2
    off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.en |-> !tick_o);
    // R7
    reload_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !tick_o);
    // R6
    single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        xtal_ce = 1'b0;
    logic        tick_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    logic [7:0] xs_sel = 8'd1;
    logic [7:0] xs_cnt = 8'd0;

    baud_tick_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .xtal_ce   (xtal_ce),
        .tick_o    (tick_o)
    );

    always #10 clk = ~clk;

    // Crystal strobe model: one pulse every xs_sel cycles, none when xs_sel is 0.
    always @(negedge clk) begin
        if (xs_sel == 8'd0) begin
            xtal_ce <= 1'b0;
            xs_cnt  <= 8'd0;
        end else if (xs_cnt >= xs_sel - 8'd1) begin
            xtal_ce <= 1'b1;
            xs_cnt  <= 8'd0;
        end else begin
            xtal_ce <= 1'b0;
            xs_cnt  <= xs_cnt + 8'd1;
        end
    end

    // Vector fields: {config word, strobe spacing, expected period in cycles}
    localparam logic [71:0] VECS [0:8] = '{
        {32'h0080_0000, 8'd1, 32'd4},    // R5 N=0
        {32'h0080_0005, 8'd1, 32'd24},   // R5 N=5
        {32'h0180_0002, 8'd1, 32'd9},    // R4 ratio 3
        {32'h0980_0003, 8'd1, 32'd8},    // R4 ratio 2
        {32'h0180_0001, 8'd4, 32'd24},   // R3 sparse strobes
        {32'h0980_0000, 8'd3, 32'd6},    // R3 ratio 2 sparse
        {32'h0880_0001, 8'd1, 32'd8},    // R5 fast flag ignored
        {32'hF680_0009, 8'd1, 32'd40},   // R9 spare bits
        {32'h0080_03E7, 8'd1, 32'd4000}  // R1 wide divisor
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk);
        cfg_wdata = w;
        cfg_wr    = 1'b1;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    // Returns the number of negedges until tick is seen (k=0 is the current one).
    task automatic wait_tick(input int limit, output int k);
        k = 0;
        while (!tick_o && k < limit) begin
            @(negedge clk);
            k++;
        end
        if (!tick_o) k = -1;
    endtask

    task automatic count_ticks(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tick_o) cnt++;
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            finish_run();
        end
    end

    initial begin
        int k;
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state is silent
        count_ticks(60, cnt);
        check(cnt == 0, "R8", cnt, 0);

        // Table walk: period between ticks, twice, plus one-cycle width
        for (int v = 0; v < 9; v++) begin
            logic [31:0] w;
            int          per;
            w      = VECS[v][71:40];
            xs_sel = VECS[v][39:32];
            per    = int'(VECS[v][31:0]);
            write_cfg(w);
            wait_tick(3 * per + 50, k);
            check(k >= 0, "R6", k, per);
            for (int r = 0; r < 2; r++) begin
                @(negedge clk);
                check(!tick_o, "R6", int'(tick_o), 0);
                wait_tick(2 * per, k);
                check(k + 1 == per, "R4/R5 period", k + 1, per);
            end
        end
        xs_sel = 8'd1;

        // R7: first tick latency after a write from the disabled state
        write_cfg(32'h0000_0000);
        write_cfg(32'h0080_0002);
        wait_tick(100, k);
        check(k == 12, "R7", k, 12);

        // R7: reload in the middle of a long count
        write_cfg(32'h0080_0032);
        count_ticks(30, cnt);
        check(cnt == 0, "R7", cnt, 0);
        write_cfg(32'h0080_0001);
        wait_tick(100, k);
        check(k == 8, "R7", k, 8);

        // R2: divisor written with enable flag clear
        write_cfg(32'h0000_0005);
        count_ticks(300, cnt);
        check(cnt == 0, "R2", cnt, 0);

        // R2: disable while running
        write_cfg(32'h0080_0000);
        count_ticks(40, cnt);
        check(cnt == 10, "R5", cnt, 10);
        write_cfg(32'h0000_0000);
        count_ticks(100, cnt);
        check(cnt == 0, "R2", cnt, 0);

        // R3: crystal selected but never strobing
        xs_sel = 8'd0;
        write_cfg(32'h0180_0000);
        count_ticks(200, cnt);
        check(cnt == 0, "R3", cnt, 0);
        xs_sel = 8'd1;
        count_ticks(90, cnt);
        check(cnt == 30, "R3", cnt, 30);

        finish_run();
    end
endmodule